// File: doc/BRIEF.md
# Shared-Buffer Packet Switch with Selectable Forwarding Mode

This block is a small packet switch, four ports by default, where every input writes into one pool of packet slots and every output reads its packets back out of that same pool. The first word of each packet carries a destination identifier and a priority. The identifier is looked up in a routing table that can be written at run time, and the table alone picks the output port. Packets move on each port as word streams that use valid and ready handshaking, with a start flag on the first word and an end flag on the last.

A run-time mode input selects when an output starts sending. In cut-through mode a queued packet starts leaving as soon as its first word is stored. In store-and-forward mode it starts leaving only after its last word is stored. A packet is admitted only if the number of free slots is above a threshold set for its priority. Each output keeps its own queue of slot numbers, so a stalled output never holds back traffic bound for another output. A slot goes back to the pool when the final word of its packet has been taken at the output. Headers whose identifier has no valid table entry are discarded and counted.

Top module: `cmsw_core`

## Requirements
- R1: Every packet leaves only on the output port held in the routing-table entry indexed by its destination identifier. The entry is written through rt_we_i, rt_idx_i, rt_port_i and rt_vld_i.
- R2: If a header carries an identifier at or above RT_DEPTH, or indexes an entry whose valid bit is clear, the header is accepted at once and the rest of the packet is discarded. err_cnt_o then rises by exactly one for each such header.
- R3: In cut-through mode (cut_through_i=1), the first word of a packet shows on an idle output in the cycle after its header was accepted at the input.
- R4: In store-and-forward mode (cut_through_i=0), the first word shows on an idle output in the cycle after the packet's last word was accepted at the input.
- R5: An output held with its ready input low does not change the latency or the delivery of packets routed to other outputs.
- R6: A header of priority p (bits DW-1:DW-2 of the header) is stored only if the free-slot count is greater than thr_i[p*FCW +: FCW]. Otherwise the packet is discarded without any output and without a change to err_cnt_o.
- R7: A slot returns to the free pool when the last word of its packet is taken at the output. After a drain, the full pool can be admitted again.
- R8: When several inputs offer headers for the same output, one header is granted per cycle in round-robin order. The inputs that are not granted keep ready low, and their packets are never interleaved with another packet.
- R9: Each delivered packet keeps all its words in order, with the start flag on the first word only and the end flag on the last word only. Each output word is held stable while ready is low.
- R10: After reset, every output valid is low, err_cnt_o is zero and every routing entry is invalid.
- R11: The destination identifier is taken from bits 8*ID_BYTES-1:0 of the header word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cut_through_i | input | 1 | 1 selects cut-through, 0 selects store-and-forward |
| rt_we_i | input | 1 | Routing-table write strobe |
| rt_idx_i | input | RT_AW | Table entry to write |
| rt_port_i | input | PW | Output port stored in the entry |
| rt_vld_i | input | 1 | Valid bit stored in the entry |
| thr_i | input | 4*FCW | Free-slot threshold for each priority, priority p at bits p*FCW |
| in_valid_i | input | NP | Input word valid, one bit per port |
| in_ready_o | output | NP | Input word ready, one bit per port |
| in_data_i | input | NP*DW | Input words, port i at bits i*DW |
| in_sop_i | input | NP | First-word flag per input |
| in_eop_i | input | NP | Last-word flag per input |
| out_valid_o | output | NP | Output word valid per port |
| out_ready_i | input | NP | Output word ready per port |
| out_data_o | output | NP*DW | Output words, port o at bits o*DW |
| out_sop_o | output | NP | First-word flag per output |
| out_eop_o | output | NP | Last-word flag per output |
| err_cnt_o | output | ERR_W | Count of discarded unroutable headers |

## Verification
The hardest situations to reach from the ports are the exact free-slot counts at which each priority threshold changes the admission decision, because slots are freed only when outputs drain. The bench holds one output's ready low. It then offers packets of each priority in turn to that output, so the pool fills one slot at a time, and it works out from the thresholds which packets must appear once ready is raised. Simultaneous headers from all four inputs to one output are offered twice in a row, and the order of their start words must rotate through the inputs.

// File: rtl/cmsw_pkg.sv
package cmsw_pkg;
  localparam int PRIO_W = 2;
  localparam int NPRIO  = 4;

  typedef enum logic [1:0] {
    IN_IDLE  = 2'd0,
    IN_WRITE = 2'd1,
    IN_DROP  = 2'd2
  } in_st_e;
endpackage

// File: rtl/cmsw_rr_arb.sv
module cmsw_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] win;
  logic          any;

  always_comb begin
    gnt_o = '0;
    win   = '0;
    any   = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (!any && req_i[idx]) begin
        any        = 1'b1;
        win        = IW'(idx);
        gnt_o[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (any) ptr_q <= (int'(win) == N - 1) ? '0 : win + 1'b1;
  end

  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt_o));
  // R8
  gnt_req_chk: assert property (@(posedge clk) disable iff (rst) (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/cmsw_route_tbl.sv
module cmsw_route_tbl #(
  parameter int NP       = 4,
  parameter int IDW      = 8,
  parameter int RT_DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we_i,
  input  logic [$clog2(RT_DEPTH)-1:0] idx_i,
  input  logic [$clog2(NP)-1:0]       port_i,
  input  logic                        vld_i,
  input  logic [NP*IDW-1:0]           ids_i,
  output logic [NP-1:0]               hit_o,
  output logic [NP*$clog2(NP)-1:0]    port_o
);
  localparam int PW    = $clog2(NP);
  localparam int RT_AW = $clog2(RT_DEPTH);

  logic [PW-1:0] ent_port [RT_DEPTH];
  logic          ent_vld  [RT_DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < RT_DEPTH; e++) begin
        ent_port[e] <= '0;
        ent_vld[e]  <= 1'b0;
      end
    end else if (we_i) begin
      ent_port[idx_i] <= port_i;
      ent_vld[idx_i]  <= vld_i;
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_look
    logic [IDW-1:0]   id;
    logic [RT_AW-1:0] low;
    assign id  = ids_i[i*IDW +: IDW];
    assign low = id[RT_AW-1:0];
    assign hit_o[i] = (int'(id) < RT_DEPTH) && ent_vld[low];
    assign port_o[i*PW +: PW] = ent_port[low];
  end
endmodule

// File: rtl/cmsw_out_port.sv
module cmsw_out_port #(
  parameter int NSLOTS     = 8,
  parameter int SLOT_WORDS = 8,
  parameter int DW         = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cut_through_i,
  input  logic                            push_i,
  input  logic [$clog2(NSLOTS)-1:0]       push_slot_i,
  output logic [$clog2(NSLOTS)-1:0]       rd_slot_o,
  output logic [$clog2(SLOT_WORDS+1)-1:0] rd_ptr_o,
  input  logic [DW-1:0]                   rd_data_i,
  input  logic [$clog2(SLOT_WORDS+1)-1:0] slot_wcnt_i,
  input  logic                            slot_done_i,
  input  logic                            out_ready_i,
  output logic                            out_valid_o,
  output logic [DW-1:0]                   out_data_o,
  output logic                            out_sop_o,
  output logic                            out_eop_o,
  output logic                            free_req_o,
  output logic [$clog2(NSLOTS)-1:0]       free_slot_o
);
  localparam int SW  = $clog2(NSLOTS);
  localparam int WW  = $clog2(SLOT_WORDS + 1);
  localparam int FCW = $clog2(NSLOTS + 1);

  logic [SW-1:0]  q [NSLOTS];
  logic [SW-1:0]  wp_q, rp_q, cur_q, oslot_q;
  logic [FCW-1:0] qcnt_q;
  logic [WW-1:0]  ptr_q;
  logic           active_q;

  logic [SW-1:0] sel;
  logic can_load, avail, last, load, pop;

  assign sel       = active_q ? cur_q : q[rp_q];
  assign rd_slot_o = sel;
  assign rd_ptr_o  = ptr_q;
  assign can_load  = !out_valid_o || out_ready_i;
  assign avail     = active_q ? (ptr_q < slot_wcnt_i)
                              : ((qcnt_q != '0) && (cut_through_i || slot_done_i));
  assign last      = slot_done_i && (WW'(ptr_q + 1'b1) == slot_wcnt_i);
  assign load      = can_load && avail;
  assign pop       = load && !active_q;

  assign free_req_o  = out_valid_o && out_ready_i && out_eop_o;
  assign free_slot_o = oslot_q;

  always_ff @(posedge clk) begin
    if (push_i) q[wp_q] <= push_slot_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q        <= '0;
      rp_q        <= '0;
      qcnt_q      <= '0;
      cur_q       <= '0;
      oslot_q     <= '0;
      ptr_q       <= '0;
      active_q    <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
    end else begin
      if (push_i) wp_q <= (int'(wp_q) == NSLOTS - 1) ? '0 : wp_q + 1'b1;
      if (pop)    rp_q <= (int'(rp_q) == NSLOTS - 1) ? '0 : rp_q + 1'b1;
      qcnt_q <= qcnt_q + FCW'(push_i) - FCW'(pop);
      if (load) begin
        out_valid_o <= 1'b1;
        out_data_o  <= rd_data_i;
        out_sop_o   <= !active_q;
        out_eop_o   <= last;
        oslot_q     <= sel;
        if (last) begin
          active_q <= 1'b0;
          ptr_q    <= '0;
        end else begin
          active_q <= 1'b1;
          cur_q    <= sel;
          ptr_q    <= ptr_q + 1'b1;
        end
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_eop_o)));
  // R7
  q_bound_chk: assert property (@(posedge clk) disable iff (rst) int'(qcnt_q) <= NSLOTS);
  // R3
  push_seen_chk: assert property (@(posedge clk) disable iff (rst) push_i |=> (qcnt_q != '0));
endmodule

// File: rtl/cmsw_core.sv
module cmsw_core
  import cmsw_pkg::*;
#(
  parameter int NP         = 4,
  parameter int DW         = 32,
  parameter int ID_BYTES   = 1,
  parameter int RT_DEPTH   = 16,
  parameter int NSLOTS     = 8,
  parameter int SLOT_WORDS = 8,
  parameter int ERR_W      = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cut_through_i,
  input  logic                                 rt_we_i,
  input  logic [$clog2(RT_DEPTH)-1:0]          rt_idx_i,
  input  logic [$clog2(NP)-1:0]                rt_port_i,
  input  logic                                 rt_vld_i,
  input  logic [NPRIO*$clog2(NSLOTS+1)-1:0]    thr_i,
  input  logic [NP-1:0]                        in_valid_i,
  output logic [NP-1:0]                        in_ready_o,
  input  logic [NP*DW-1:0]                     in_data_i,
  input  logic [NP-1:0]                        in_sop_i,
  input  logic [NP-1:0]                        in_eop_i,
  output logic [NP-1:0]                        out_valid_o,
  input  logic [NP-1:0]                        out_ready_i,
  output logic [NP*DW-1:0]                     out_data_o,
  output logic [NP-1:0]                        out_sop_o,
  output logic [NP-1:0]                        out_eop_o,
  output logic [ERR_W-1:0]                     err_cnt_o
);
  localparam int PW   = $clog2(NP);
  localparam int IDW  = 8 * ID_BYTES;
  localparam int SW   = $clog2(NSLOTS);
  localparam int WW   = $clog2(SLOT_WORDS + 1);
  localparam int FCW  = $clog2(NSLOTS + 1);
  localparam int MEMW = NSLOTS * SLOT_WORDS;
  localparam int AW   = $clog2(MEMW);

  function automatic logic [AW-1:0] maddr(logic [SW-1:0] s, logic [WW-1:0] p);
    return AW'(int'(s) * SLOT_WORDS + int'(p));
  endfunction

  logic [DW-1:0]       din  [NP];
  logic [PRIO_W-1:0]   pri  [NP];
  logic [NP*IDW-1:0]   ids_flat;
  logic [NP-1:0]       hit;
  logic [NP*PW-1:0]    rport_flat;

  for (genvar i = 0; i < NP; i++) begin : g_in
    assign din[i] = in_data_i[i*DW +: DW];
    assign pri[i] = din[i][DW-1 -: PRIO_W];
    assign ids_flat[i*IDW +: IDW] = din[i][IDW-1:0];
  end

  cmsw_route_tbl #(.NP(NP), .IDW(IDW), .RT_DEPTH(RT_DEPTH)) u_rt (
    .clk(clk), .rst(rst), .we_i(rt_we_i), .idx_i(rt_idx_i), .port_i(rt_port_i),
    .vld_i(rt_vld_i), .ids_i(ids_flat), .hit_o(hit), .port_o(rport_flat)
  );

  in_st_e         st_q   [NP];
  logic [SW-1:0]  cslot_q[NP];
  logic [WW-1:0]  wptr_q [NP];
  logic [NSLOTS-1:0] free_q, done_q;
  logic [WW-1:0]  wcnt_q [NSLOTS];
  logic [ERR_W-1:0] err_q;
  logic [DW-1:0]  mem [MEMW];

  logic [NP-1:0]  hdr, bad, gnt_in, adm, wr_en;
  logic [SW-1:0]  aslot [NP];
  logic [AW-1:0]  wr_addr [NP];
  logic [NP-1:0]  req_o [NP];
  logic [NP-1:0]  gnt_o [NP];
  logic [NP-1:0]  push;
  logic [SW-1:0]  push_slot [NP];
  logic [SW-1:0]  rd_slot [NP];
  logic [WW-1:0]  rd_ptr  [NP];
  logic [NP-1:0]  free_req;
  logic [SW-1:0]  free_slot [NP];

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      hdr[i] = (st_q[i] == IN_IDLE) && in_valid_i[i] && in_sop_i[i];
      bad[i] = hdr[i] && !hit[i];
    end
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        req_o[o][i] = hdr[i] && hit[i] && (rport_flat[i*PW +: PW] == PW'(o));
  end

  for (genvar o = 0; o < NP; o++) begin : g_arb
    cmsw_rr_arb #(.N(NP)) u_arb (.clk(clk), .rst(rst), .req_i(req_o[o]), .gnt_o(gnt_o[o]));
  end

  // admission and slot allocation, lower input index allocates first
  always_comb begin
    logic [NSLOTS-1:0] avail;
    logic [FCW-1:0]    cnt;
    avail = free_q;
    cnt   = FCW'($countones(free_q));
    for (int i = 0; i < NP; i++) begin
      gnt_in[i] = 1'b0;
      for (int o = 0; o < NP; o++) gnt_in[i] = gnt_in[i] | gnt_o[o][i];
      adm[i]   = 1'b0;
      aslot[i] = '0;
      if (gnt_in[i] && (cnt > thr_i[int'(pri[i])*FCW +: FCW])) begin
        for (int s = NSLOTS - 1; s >= 0; s--)
          if (avail[s]) aslot[i] = SW'(s);
        avail[aslot[i]] = 1'b0;
        cnt    = cnt - 1'b1;
        adm[i] = 1'b1;
      end
    end
    for (int o = 0; o < NP; o++) begin
      push[o]      = |(gnt_o[o] & adm);
      push_slot[o] = '0;
      for (int i = 0; i < NP; i++)
        if (gnt_o[o][i]) push_slot[o] = aslot[i];
    end
    for (int i = 0; i < NP; i++) begin
      if (st_q[i] != IN_IDLE || !hdr[i] || !hit[i]) in_ready_o[i] = 1'b1;
      else in_ready_o[i] = gnt_in[i];
      wr_en[i]   = 1'b0;
      wr_addr[i] = '0;
      if (hdr[i] && adm[i]) begin
        wr_en[i]   = 1'b1;
        wr_addr[i] = maddr(aslot[i], '0);
      end else if (st_q[i] == IN_WRITE && in_valid_i[i] && int'(wptr_q[i]) < SLOT_WORDS) begin
        wr_en[i]   = 1'b1;
        wr_addr[i] = maddr(cslot_q[i], wptr_q[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NP; i++)
      if (wr_en[i]) mem[wr_addr[i]] <= din[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= '1;
      done_q <= '0;
      err_q  <= '0;
      for (int s = 0; s < NSLOTS; s++) wcnt_q[s] <= '0;
      for (int i = 0; i < NP; i++) begin
        st_q[i]    <= IN_IDLE;
        cslot_q[i] <= '0;
        wptr_q[i]  <= '0;
      end
    end else begin
      err_q <= err_q + ERR_W'($countones(bad));
      for (int o = 0; o < NP; o++)
        if (free_req[o]) free_q[free_slot[o]] <= 1'b1;
      for (int i = 0; i < NP; i++) begin
        case (st_q[i])
          IN_IDLE: begin
            if (hdr[i] && !hit[i]) begin
              if (!in_eop_i[i]) st_q[i] <= IN_DROP;
            end else if (hdr[i] && gnt_in[i]) begin
              if (adm[i]) begin
                free_q[aslot[i]] <= 1'b0;
                wcnt_q[aslot[i]] <= WW'(1);
                done_q[aslot[i]] <= in_eop_i[i];
                cslot_q[i]       <= aslot[i];
                wptr_q[i]        <= WW'(1);
                if (!in_eop_i[i]) st_q[i] <= IN_WRITE;
              end else if (!in_eop_i[i]) begin
                st_q[i] <= IN_DROP;
              end
            end
          end
          IN_WRITE: begin
            if (in_valid_i[i]) begin
              if (int'(wptr_q[i]) < SLOT_WORDS) begin
                wcnt_q[cslot_q[i]] <= wptr_q[i] + 1'b1;
                wptr_q[i]          <= wptr_q[i] + 1'b1;
              end
              if (in_eop_i[i]) begin
                done_q[cslot_q[i]] <= 1'b1;
                st_q[i]            <= IN_IDLE;
              end
            end
          end
          default: begin
            if (in_valid_i[i] && in_eop_i[i]) st_q[i] <= IN_IDLE;
          end
        endcase
      end
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    logic [DW-1:0] rdat;
    assign rdat = mem[maddr(rd_slot[o], rd_ptr[o])];
    cmsw_out_port #(.NSLOTS(NSLOTS), .SLOT_WORDS(SLOT_WORDS), .DW(DW)) u_op (
      .clk(clk), .rst(rst), .cut_through_i(cut_through_i),
      .push_i(push[o]), .push_slot_i(push_slot[o]),
      .rd_slot_o(rd_slot[o]), .rd_ptr_o(rd_ptr[o]), .rd_data_i(rdat),
      .slot_wcnt_i(wcnt_q[rd_slot[o]]), .slot_done_i(done_q[rd_slot[o]]),
      .out_ready_i(out_ready_i[o]), .out_valid_o(out_valid_o[o]),
      .out_data_o(out_data_o[o*DW +: DW]), .out_sop_o(out_sop_o[o]),
      .out_eop_o(out_eop_o[o]), .free_req_o(free_req[o]), .free_slot_o(free_slot[o])
    );
  end

  assign err_cnt_o = err_q;

  // R2
  err_step_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q - $past(err_q)) <= ERR_W'(NP));
endmodule

// File: tb/cmsw_core_bench.sv
module cmsw_core_bench;
  localparam int NP = 4, DW = 32, FCW = 4;

  logic clk = 1'b0;
  logic rst;
  logic cut;
  logic rt_we, rt_vld;
  logic [3:0] rt_idx;
  logic [1:0] rt_port;
  logic [4*FCW-1:0] thr;
  logic [NP-1:0] iv, is, ie, irdy, ov, ordy, osop, oeop;
  logic [DW-1:0] bd [NP];
  logic [NP*DW-1:0] idata, odata;
  logic [15:0] err;

  for (genvar i = 0; i < NP; i++) begin : g_pk
    assign idata[i*DW +: DW] = bd[i];
  end

  cmsw_core u_cmsw_core (
    .clk(clk), .rst(rst), .cut_through_i(cut), .rt_we_i(rt_we), .rt_idx_i(rt_idx),
    .rt_port_i(rt_port), .rt_vld_i(rt_vld), .thr_i(thr), .in_valid_i(iv),
    .in_ready_o(irdy), .in_data_i(idata), .in_sop_i(is), .in_eop_i(ie),
    .out_valid_o(ov), .out_ready_i(ordy), .out_data_o(odata), .out_sop_o(osop),
    .out_eop_o(oeop), .err_cnt_o(err)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nbad = 0, next_tag = 0, n0 = 0;
  bit finished = 0;
  int tag_port [256], tag_len [256], tag_id [256], tag_pri [256], tag_in [256];
  int hdr_cyc [256], eop_cyc [256], deliv [256];
  bit tag_ok [256], tag_ct [256];
  string tag_lab [256];
  int log0 [256];
  int cur_t [NP], cur_k [NP];

  task automatic chk(bit ok, string r, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic logic [31:0] hw(int t, int id, int p);
    return {p[1:0], 6'd0, t[7:0], 8'd0, id[7:0]};
  endfunction
  function automatic logic [31:0] pw(int t, int k);
    return {8'h5A, t[7:0], 8'h00, k[7:0]};
  endfunction
  function automatic int port_of(int id);
    return (id < 12) ? (3 * id + 1) % 4 : -1;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  endtask

  // output monitor: checks R1, R3, R4, R5, R9, R11 per delivered word
  always @(negedge clk) begin
    if (!rst) begin
      for (int o = 0; o < NP; o++) begin
        if (ov[o] && ordy[o]) begin
          logic [31:0] w;
          int t;
          w = odata[o*DW +: DW];
          if (osop[o]) begin
            t = int'(w[23:16]);
            cur_t[o] = t;
            cur_k[o] = 1;
            deliv[t]++;
            chk(tag_ok[t] && tag_port[t] == o, "R1 port", o, tag_port[t]);
            chk(w == hw(t, tag_id[t], tag_pri[t]), "R11 header", w, hw(t, tag_id[t], tag_pri[t]));
            chk(oeop[o] == (tag_len[t] == 1), "R9 eop", oeop[o], tag_len[t] == 1);
            if (tag_lab[t] != "") begin
              if (tag_ct[t]) chk(cyc == hdr_cyc[t] + 1, tag_lab[t], cyc, hdr_cyc[t] + 1);
              else chk(cyc == eop_cyc[t] + 1, tag_lab[t], cyc, eop_cyc[t] + 1);
            end
            if (o == 0) begin
              log0[n0] = t;
              n0++;
            end
          end else begin
            t = cur_t[o];
            chk(w == pw(t, cur_k[o]), "R9 word", w, pw(t, cur_k[o]));
            chk(oeop[o] == (cur_k[o] == tag_len[t] - 1), "R9 eop", oeop[o], cur_k[o] == tag_len[t] - 1);
            cur_k[o]++;
          end
        end
      end
    end
  end

  task automatic send(int i, int id, int p, int len, bit adm_ok, string lab);
    int t;
    t = next_tag;
    next_tag++;
    tag_port[t] = port_of(id);
    tag_len[t] = len;
    tag_id[t] = id;
    tag_pri[t] = p;
    tag_in[t] = i;
    tag_ok[t] = (port_of(id) >= 0) && adm_ok;
    tag_ct[t] = cut;
    tag_lab[t] = lab;
    for (int w = 0; w < len; w++) begin
      @(negedge clk);
      iv[i] = 1'b1;
      is[i] = (w == 0);
      ie[i] = (w == len - 1);
      bd[i] = (w == 0) ? hw(t, id, p) : pw(t, w);
      #1;
      while (!irdy[i]) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
      if (w == 0) hdr_cyc[t] = cyc + 1;
      if (w == len - 1) eop_cyc[t] = cyc + 1;
    end
    @(negedge clk);
    iv[i] = 1'b0;
    is[i] = 1'b0;
    ie[i] = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    int stored;
    int th [4];
    rst = 1'b1; cut = 1'b1; rt_we = 0; rt_vld = 0; rt_idx = 0; rt_port = 0;
    thr = '0; iv = '0; is = '0; ie = '0; ordy = '1;
    for (int i = 0; i < NP; i++) bd[i] = '0;
    for (int t = 0; t < 256; t++) deliv[t] = 0;
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    idle(2);
    // R10 reset state
    chk(ov == '0, "R10 out_valid", ov, 0);
    chk(err == 0, "R10 err", err, 0);
    chk(irdy == '1, "R10 ready", irdy, 15);
    // R10 empty table: everything unroutable
    tag_ok[0] = 0;
    send(0, 1, 0, 3, 1'b1, "");
    tag_ok[0] = 0;
    idle(4);
    chk(err == 1, "R10 table empty", err, 1);

    for (int d = 0; d < 16; d++) begin
      @(negedge clk);
      rt_we = 1; rt_idx = 4'(d); rt_port = 2'(port_of(d < 12 ? d : 0)); rt_vld = (d < 12);
    end
    @(negedge clk);
    rt_we = 0;

    // sweep: both modes, every input, every identifier 0..17
    for (int m = 0; m < 2; m++) begin
      cut = (m == 0);
      for (int i = 0; i < NP; i++)
        for (int id = 0; id < 18; id++) begin
          send(i, id, id % 4, 1 + (i + id) % 8, 1'b1, (m == 0) ? "R3 ct latency" : "R4 saf latency");
          idle(10);
        end
    end
    chk(err == 49, "R2 err count", err, 49);

    // R5: blocked output 0 must not delay output 1
    cut = 1'b1;
    @(posedge clk); #2 ordy[0] = 1'b0;
    send(0, 1, 0, 4, 1'b1, "");
    send(1, 0, 0, 3, 1'b1, "R5 other output latency");
    idle(6);
    chk(deliv[next_tag - 1] == 1, "R5 delivered while blocked", deliv[next_tag - 1], 1);
    chk(deliv[next_tag - 2] == 0, "R5 blocked held", deliv[next_tag - 2], 0);
    @(posedge clk); #2 ordy[0] = 1'b1;
    idle(30);

    // R6 admission thresholds with output 0 blocked, R7 freeing
    th[0] = 5; th[1] = 3; th[2] = 1; th[3] = 0;
    thr = {4'(th[3]), 4'(th[2]), 4'(th[1]), 4'(th[0])};
    @(posedge clk); #2 ordy[0] = 1'b0;
    stored = 0;
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 4; p++) begin
        bit ok;
        ok = (8 - stored) > th[p];
        send((r + p) % 4, 5, p, 2, ok, "");
        if (ok) stored++;
        idle(2);
      end
    chk(stored == 8, "R6 pool filled", stored, 8);
    chk(err == 49, "R6 no error count", err, 49);
    @(posedge clk); #2 ordy[0] = 1'b1;
    idle(40);
    send(2, 5, 0, 3, 1'b1, "R7 after drain");
    idle(10);
    chk(deliv[next_tag - 1] == 1, "R7 readmitted", deliv[next_tag - 1], 1);
    thr = '0;

    // R8 round robin among four simultaneous headers, two rounds
    for (int rnd = 0; rnd < 2; rnd++) begin
      int base;
      base = n0;
      fork
        send(0, 1, 1, 3, 1'b1, "");
        send(1, 1, 1, 3, 1'b1, "");
        send(2, 1, 1, 3, 1'b1, "");
        send(3, 1, 1, 3, 1'b1, "");
      join
      idle(30);
      chk(n0 == base + 4, "R8 all delivered", n0, base + 4);
      for (int j = 0; j < 3; j++)
        chk(tag_in[log0[base + j + 1]] == (tag_in[log0[base + j]] + 1) % 4,
            "R8 rotation", tag_in[log0[base + j + 1]], (tag_in[log0[base + j]] + 1) % 4);
    end

    // every packet delivered exactly when expected
    for (int t = 0; t < next_tag; t++)
      chk(deliv[t] == (tag_ok[t] ? 1 : 0), "R6 delivery count", deliv[t], tag_ok[t] ? 1 : 0);
    summary();
  end
endmodule